// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block is the central reset controller of a processor supervisor. Its inputs are the undervoltage flags of two supply comparators, one tight and one loose, a select line that picks which flag counts as a fault, a debounced manual reset request and a watchdog timeout request. Its outputs are an active-high reset and an active-low reset. The active-low reset is modelled as a drive-low enable: when the enable is high the pad is pulled down, and when it is low the pad is released to its external pull-up.

Any active cause asserts reset on the next clock edge. The fault path does not wait for the millisecond tick. Once every cause has cleared, reset stays asserted for a hold time of HOLD_TICKS ticks, and each tick is CLK_PER_TICK clock cycles. If any cause reappears during the hold, the full hold starts again. The synchronous clear leaves the block with reset asserted and the hold loaded, so power-up produces a full-length reset pulse.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `clr` is high and in the cycle after it is released, `rst_o` is 1 and `rst_n_oe_o` is 1.
- R2: With `tol_loose_i`=0 the tight flag `uv_tight_i` is the supply fault. It asserts reset at the first clock edge that samples it high. `uv_loose_i` has no effect on reset in this mode.
- R3: With `tol_loose_i`=1 the loose flag `uv_loose_i` is the supply fault and asserts reset at the next edge. `uv_tight_i` has no effect on reset in this mode.
- R4: A high `man_rst_i` asserts reset at the next clock edge.
- R5: A high `wdog_to_i` asserts reset at the next clock edge.
- R6: Reset is released exactly HOLD_TICKS*CLK_PER_TICK clock edges after the last edge that sampled an active cause.
- R7: An active cause seen during the hold restarts the hold, and the release follows R6 counted from that cause.
- R8: `rst_n_oe_o` always equals `rst_o`, so the pad level of the active-low reset is always the complement of `rst_o`. Both outputs change on the same edge.
- R9: After `clr` falls, reset is held for the full time given in R6, counted from the last edge that sampled `clr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear (power-up) |
| uv_tight_i | input | 1 | Undervoltage flag, tight threshold |
| uv_loose_i | input | 1 | Undervoltage flag, loose threshold |
| tol_loose_i | input | 1 | 0 selects the tight flag, 1 selects the loose flag |
| man_rst_i | input | 1 | Debounced manual reset request |
| wdog_to_i | input | 1 | Watchdog timeout request |
| rst_o | output | 1 | Active-high reset |
| rst_n_oe_o | output | 1 | Drive-low enable of the active-low reset |

## Verification
The bench builds the block with CLK_PER_TICK=4 and HOLD_TICKS=5, which gives a 20-cycle hold. At that length every release point can be measured to the exact cycle, and a restart in the middle of the hold can be placed cleanly between tick boundaries. A tick length above one also keeps the prescaler restart in play: a cause that lands partway through a tick would shorten the hold if the prescaler were not cleared.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic {
        TOL_TIGHT = 1'b0,
        TOL_LOOSE = 1'b1
    } tol_sel_t;

    typedef struct packed {
        logic uv_tight;
        logic uv_loose;
        logic manual;
        logic wdog;
    } rpg_cause_t;

    function automatic logic supply_fault(input rpg_cause_t c, input tol_sel_t sel);
        return (sel == TOL_LOOSE) ? c.uv_loose : c.uv_tight;
    endfunction

endpackage

// File: rtl/rpg_cause_merge.sv
module rpg_cause_merge
    import rpg_pkg::*;
(
    input  rpg_cause_t cause_i,
    input  tol_sel_t   sel_i,
    output logic       any_o
);
    always_comb begin
        any_o = supply_fault(cause_i, sel_i) | cause_i.manual | cause_i.wdog;
    end
endmodule

// File: rtl/rpg_tick.sv
module rpg_tick #(
    parameter int CLK_PER_TICK = 125000
) (
    input  logic clk,
    input  logic clr,
    input  logic restart_i,
    output logic tick_o
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(CLK_PER_TICK);
            localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (clr || restart_i || pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick_o = (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rpg_hold.sv
module rpg_hold #(
    parameter int HOLD_TICKS = 610
) (
    input  logic clk,
    input  logic clr,
    input  logic cause_i,
    input  logic tick_i,
    output logic rst_o,
    output logic rst_n_oe_o
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          act_d;

    always_comb begin
        if (cause_i) begin
            cnt_d = FULL;
        end else if (tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        act_d = cause_i | (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q      <= FULL;
            rst_o      <= 1'b1;
            rst_n_oe_o <= 1'b1;
        end else begin
            cnt_q      <= cnt_d;
            rst_o      <= act_d;
            rst_n_oe_o <= act_d;
        end
    end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
    import rpg_pkg::*;
#(
    parameter int CLK_PER_TICK = 125000,
    parameter int HOLD_TICKS   = 610
) (
    input  logic clk,
    input  logic clr,
    input  logic uv_tight_i,
    input  logic uv_loose_i,
    input  logic tol_loose_i,
    input  logic man_rst_i,
    input  logic wdog_to_i,
    output logic rst_o,
    output logic rst_n_oe_o
);
    rpg_cause_t causes;
    tol_sel_t   sel;
    logic       cause_any;
    logic       tick;

    assign causes = '{uv_tight: uv_tight_i, uv_loose: uv_loose_i,
                      manual: man_rst_i, wdog: wdog_to_i};
    assign sel    = tol_sel_t'(tol_loose_i);

    rpg_cause_merge u_merge (
        .cause_i (causes),
        .sel_i   (sel),
        .any_o   (cause_any)
    );

    rpg_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk       (clk),
        .clr       (clr),
        .restart_i (cause_any),
        .tick_o    (tick)
    );

    rpg_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk        (clk),
        .clr        (clr),
        .cause_i    (cause_any),
        .tick_i     (tick),
        .rst_o      (rst_o),
        .rst_n_oe_o (rst_n_oe_o)
    );
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
    parameter int CLK_PER_TICK = 125000,
    parameter int HOLD_TICKS   = 610
) (
    input logic clk,
    input logic clr,
    input logic uv_tight_i,
    input logic uv_loose_i,
    input logic tol_loose_i,
    input logic man_rst_i,
    input logic wdog_to_i,
    input logic rst_o,
    input logic rst_n_oe_o
);
    localparam longint LIMIT = longint'(HOLD_TICKS) * longint'(CLK_PER_TICK < 1 ? 1 : CLK_PER_TICK);
    localparam int QW = $clog2(LIMIT + 1);
    localparam logic [QW-1:0] QMAX = QW'(LIMIT);

    logic          fault;
    logic [QW-1:0] quiet_q;

    assign fault = (tol_loose_i ? uv_loose_i : uv_tight_i) | man_rst_i | wdog_to_i;

    always_ff @(posedge clk) begin
        if (clr || fault) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_clear_state_R1: assert property (@(posedge clk) $past(clr) |-> (rst_o && rst_n_oe_o));

    assert_fault_asserts_R2_R3: assert property (@(posedge clk) disable iff (clr)
        (tol_loose_i ? uv_loose_i : uv_tight_i) |=> rst_o);

    assert_manual_R4: assert property (@(posedge clk) disable iff (clr) man_rst_i |=> rst_o);

    assert_wdog_R5: assert property (@(posedge clk) disable iff (clr) wdog_to_i |=> rst_o);

    assert_release_time_R6: assert property (@(posedge clk) disable iff (clr)
        $fell(rst_o) |-> (quiet_q == QMAX));

    assert_hold_kept_R7_R9: assert property (@(posedge clk) disable iff (clr)
        (quiet_q != QMAX) |-> rst_o);

    assert_complement_R8: assert property (@(posedge clk) disable iff (clr) rst_n_oe_o == rst_o);
endmodule

bind rst_pulse_gen rpg_checker #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .HOLD_TICKS  (HOLD_TICKS)
) u_chk (
    .clk         (clk),
    .clr         (clr),
    .uv_tight_i  (uv_tight_i),
    .uv_loose_i  (uv_loose_i),
    .tol_loose_i (tol_loose_i),
    .man_rst_i   (man_rst_i),
    .wdog_to_i   (wdog_to_i),
    .rst_o       (rst_o),
    .rst_n_oe_o  (rst_n_oe_o)
);

// File: tb/sim_rst_pulse_gen.sv
`timescale 1ns/1ps
module sim_rst_pulse_gen;
    localparam int P  = 4;
    localparam int H  = 5;
    localparam int HP = P * H;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic uv_tight_i = 1'b0, uv_loose_i = 1'b0, tol_loose_i = 1'b0;
    logic man_rst_i = 1'b0, wdog_to_i = 1'b0;
    logic rst_o, rst_n_oe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rst_pulse_gen #(.CLK_PER_TICK(P), .HOLD_TICKS(H)) u0 (
        .clk(clk), .clr(clr), .uv_tight_i(uv_tight_i), .uv_loose_i(uv_loose_i),
        .tol_loose_i(tol_loose_i), .man_rst_i(man_rst_i), .wdog_to_i(wdog_to_i),
        .rst_o(rst_o), .rst_n_oe_o(rst_n_oe_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cause was just dropped at a negedge. Counts negedges until reset releases.
    task automatic measure_release(input string req);
        int n = 0;
        int mism = 0;
        for (int k = 1; k <= 3 * HP; k++) begin
            @(negedge clk);
            if (rst_o != rst_n_oe_o) mism++;
            if (!rst_o) begin
                n = k;
                break;
            end
        end
        check(n == HP, req, n, HP);
        check(mism == 0, "R8", mism, 0);
    endtask

    task automatic expect_assert_next(input string req);
        @(negedge clk);
        check(rst_o == 1'b1 && rst_n_oe_o == 1'b1, req, rst_o, 1);
    endtask

    task automatic t_powerup();
        repeat (3) @(negedge clk);
        check(rst_o == 1'b1 && rst_n_oe_o == 1'b1, "R1", rst_o, 1);
        clr = 1'b0;
        measure_release("R9");
    endtask

    task automatic t_tight();
        int highs = 0;
        tol_loose_i = 1'b0;
        uv_loose_i  = 1'b1;               // R2: loose flag ignored in tight mode
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rst_o) highs++;
        end
        check(highs == 0, "R2", highs, 0);
        uv_loose_i = 1'b0;
        uv_tight_i = 1'b1;
        expect_assert_next("R2");
        repeat (3) @(negedge clk);
        uv_tight_i = 1'b0;
        measure_release("R6");
    endtask

    task automatic t_loose();
        int highs = 0;
        tol_loose_i = 1'b1;
        uv_tight_i  = 1'b1;               // R3: tight flag ignored in loose mode
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (rst_o) highs++;
        end
        check(highs == 0, "R3", highs, 0);
        uv_tight_i = 1'b0;
        uv_loose_i = 1'b1;
        expect_assert_next("R3");
        uv_loose_i = 1'b0;
        measure_release("R6");
        tol_loose_i = 1'b0;
    endtask

    task automatic t_manual();
        man_rst_i = 1'b1;
        expect_assert_next("R4");
        repeat (5) @(negedge clk);
        man_rst_i = 1'b0;
        measure_release("R4");
    endtask

    task automatic t_wdog();
        @(negedge clk);
        wdog_to_i = 1'b1;
        expect_assert_next("R5");
        wdog_to_i = 1'b0;
        measure_release("R5");
    endtask

    task automatic t_glitch();
        man_rst_i = 1'b1;
        @(negedge clk);
        man_rst_i = 1'b0;
        repeat (HP - 3) @(negedge clk);
        check(rst_o == 1'b1, "R7", rst_o, 1);
        uv_tight_i = 1'b1;                // one-cycle glitch late in the hold
        @(negedge clk);
        uv_tight_i = 1'b0;
        measure_release("R7");
        // second glitch that lands mid-tick
        wdog_to_i = 1'b1;
        @(negedge clk);
        wdog_to_i = 1'b0;
        repeat (6) @(negedge clk);
        wdog_to_i = 1'b1;
        @(negedge clk);
        wdog_to_i = 1'b0;
        measure_release("R7");
    endtask

    initial begin
        t_powerup();
        t_tight();
        t_loose();
        t_manual();
        t_wdog();
        t_glitch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule